// File: doc/BRIEF.md
# Single-Slope Converter Column Controller

This block is the digital half of a column-parallel single-slope analog-to-digital converter. One shared synchronous up-counter produces the code that drives the ramp generator. Every column has its own capture register that freezes the counter value in the cycle its comparator first reports that the ramp has passed the column's sampled voltage. The analog ramp, the comparators and the correlated double sampling sit outside the block. Only the comparator decisions come in, one bit per column.

A conversion starts on a low-to-high transition of the start line. The counter then climbs from zero to full scale, one step per clock. When the counter reaches full scale, any column whose comparator never fired is forced to the full-scale value. One clock later a single-cycle done pulse marks all results as valid. The counter then parks at full scale until the next start transition. A new start transition during a conversion abandons that conversion and begins a fresh one.

Top module: `ssadc_ctrl`

## Requirements
- R1: A conversion begins on the first clock edge at which `start` is 1 after having been sampled 0. At that edge `ramp_code` becomes 0 and every result field becomes 0. Keeping `start` at 1 afterwards starts nothing further.
- R2: While a conversion runs, `ramp_code` rises by exactly 1 on every clock edge, from 0 up to 4095 (all ones for the default width of 12).
- R3: The counter is made of per-bit toggle stages whose toggle enables are all formed in parallel from the lower bits. Every carry boundary is crossed correctly, for example 127 to 128 and 2047 to 2048.
- R4: Column c's result occupies `result[c*12 +: 12]`. It receives the `ramp_code` value present in the first cycle of the conversion in which `cmp[c]` is 1.
- R5: After a column has captured, further changes of its `cmp` bit in the same conversion leave its result unchanged.
- R6: A column whose `cmp` bit is still 0 when `ramp_code` is 4095 ends the conversion with result 4095.
- R7: `done` is 1 for exactly one cycle. That cycle follows the first cycle in which `ramp_code` shows 4095, which is 4097 cycles after the start edge. Afterwards `ramp_code` stays at 4095 and the results stay unchanged until the next start.
- R8: A start transition during a running conversion restarts it. `ramp_code` returns to 0, results clear to 0, and `done` comes 4097 cycles after the new start edge.
- R9: Synchronous active-high `rst` sets `ramp_code`, `done` and all results to 0 and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion start; a 0-to-1 transition begins a conversion |
| cmp | input | NCOL (32) | Comparator decisions, bit c for column c; 1 means the ramp has passed the column input |
| ramp_code | output | W (12) | Registered counter value that drives the ramp generator |
| result | output | NCOL*W (384) | Per-column captured codes, column c in bits c*W +: W |
| done | output | 1 | One-cycle pulse marking the end of a conversion |

## Verification
The comparator is modelled in the bench as "ramp code greater than the column's input value". Each full-scale conversion is tried with a different set of column inputs. Small consecutive inputs separate off-by-one capture errors in the low bits. Inputs just below multiples of 128 force captures across counter carry boundaries. Inputs at and above full scale separate a late real capture from saturation. A pattern in which every comparator chatters after firing shows whether later transitions are ignored. A conversion cut short by a second start transition checks that the counter and results clear and that the done timing is counted from the new start.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/ssadc_counter.sv
module ssadc_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         at_max
);
  logic [W-1:0] tgl;

  // Per-bit toggle stages; each toggle enable is one wide AND of lower bits.
  for (genvar i = 0; i < W; i++) begin : g_stage
    logic bit_q;
    if (i == 0) begin : g_lsb
      assign tgl[i] = 1'b1;
    end else begin : g_upper
      assign tgl[i] = &q[i-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        bit_q <= 1'b0;
      end else if (en && tgl[i]) begin
        bit_q <= ~bit_q;
      end
    end

    assign q[i] = bit_q;
  end

  assign at_max = &q;

  // R2 / R3: one step per enabled cycle, across every carry
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (en && !clr) |=> (q == $past(q) + 1'b1));

  // R7: counter parks when not enabled
  a_r7_park: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(q));
endmodule

// File: rtl/ssadc_sequencer.sv
module ssadc_sequencer (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic at_max,
  output logic conv_clr,
  output logic cnt_en,
  output logic running,
  output logic term,
  output logic done
);
  import ssadc_pkg::*;

  phase_t phase;
  logic   start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= start;
  end

  assign conv_clr = start && !start_q;
  assign running  = (phase == PH_RUN);
  assign term     = running && at_max;
  assign cnt_en   = running && !at_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      done <= term && !conv_clr;
      if (conv_clr)  phase <= PH_RUN;
      else if (term) phase <= PH_IDLE;
    end
  end

  // R1: a start transition always leaves the block running
  a_r1_start_runs: assert property (@(posedge clk) disable iff (rst)
    conv_clr |=> running);

  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: done never coincides with a running conversion
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !running);
endmodule

// File: rtl/ssadc_column.sv
module ssadc_column #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         running,
  input  logic         term,
  input  logic         cmp,
  input  logic [W-1:0] code,
  output logic [W-1:0] result
);
  logic captured;
  logic hit;

  assign hit = running && !captured && cmp;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      result   <= '0;
      captured <= 1'b0;
    end else if (hit) begin
      result   <= code;
      captured <= 1'b1;
    end else if (term && !captured) begin
      result   <= '1;
      captured <= 1'b1;
    end
  end

  // R5: once captured, the result is frozen until the next clear
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    (captured && !clr) |=> $stable(result));

  // R6: no comparator decision by full scale gives the full-scale code
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (term && !captured && !clr) |=> (result == {W{1'b1}}));

  // R1: a clear empties the register
  a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> (result == '0));
endmodule

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl #(
  parameter int NCOL = 32,
  parameter int W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NCOL-1:0]   cmp,
  output logic [W-1:0]      ramp_code,
  output logic [NCOL*W-1:0] result,
  output logic              done
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic conv_clr, cnt_en, running, term, at_max;

  ssadc_sequencer u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .at_max  (at_max),
    .conv_clr(conv_clr),
    .cnt_en  (cnt_en),
    .running (running),
    .term    (term),
    .done    (done)
  );

  ssadc_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr   (conv_clr),
    .en    (cnt_en),
    .q     (ramp_code),
    .at_max(at_max)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    ssadc_column #(.W(W)) u_col (
      .clk    (clk),
      .rst    (rst),
      .clr    (conv_clr),
      .running(running),
      .term   (term),
      .cmp    (cmp[c]),
      .code   (ramp_code),
      .result (result[c*W +: W])
    );
  end

  // R7: done appears only while the counter sits at full scale
  a_r7_done_full: assert property (@(posedge clk) disable iff (rst)
    done |-> (ramp_code == FULL));

  // R1: a start transition zeroes the ramp code
  a_r1_ramp_zero: assert property (@(posedge clk) disable iff (rst)
    (start && !$past(start)) |=> (ramp_code == '0));
endmodule

// File: tb/ssadc_ctrl_bench.sv
module ssadc_ctrl_bench;
  localparam int NCOL = 32;
  localparam int W    = 12;
  localparam int MAXV = 4095;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [NCOL-1:0]   cmp;
  logic [W-1:0]      ramp_code;
  logic [NCOL*W-1:0] result;
  logic              done;

  int vin [NCOL];
  bit glitch = 1'b0;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ssadc_ctrl #(.NCOL(NCOL), .W(W)) u_ssadc_ctrl (
    .clk(clk), .rst(rst), .start(start), .cmp(cmp),
    .ramp_code(ramp_code), .result(result), .done(done)
  );

  // Behavioural comparator: fires once the ramp code exceeds the input,
  // optionally chattering after it has fired.
  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      cmp[c] = (int'(ramp_code) > vin[c]) &&
               !(glitch && (int'(ramp_code) > vin[c] + 3) && ramp_code[0]);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int col_res(input int c);
    return int'(result[c*W +: W]);
  endfunction

  function automatic int expect_res(input int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  task automatic run_conv(input string req, input int abort_at);
    int n;
    int bad_ramp;
    int bad_hold;
    @(negedge clk) start = 1'b0;
    @(negedge clk) start = 1'b1;
    n = 0;
    bad_ramp = 0;
    if (abort_at > 0) begin
      repeat (abort_at) @(negedge clk);
      start = 1'b0;
      @(negedge clk) start = 1'b1;
      @(negedge clk);
      chk(ramp_code == 0, "R8", "ramp after restart", int'(ramp_code), 0);
      chk(col_res(0) == 0, "R8", "col0 cleared on restart", col_res(0), 0);
      chk(col_res(NCOL/2) == 0, "R1", "result cleared on start", col_res(NCOL/2), 0);
      n = 1;
    end
    while (!done && n < 5000) begin
      if (n >= 1 && int'(ramp_code) != n - 1) bad_ramp++;
      @(negedge clk);
      n++;
    end
    chk(n == 4097, "R7", "done arrival cycle", n, 4097);
    chk(bad_ramp == 0, "R2", "ramp step mismatches", bad_ramp, 0);
    for (int c = 0; c < NCOL; c++) begin
      chk(col_res(c) == expect_res(vin[c]), req, $sformatf("column %0d", c),
          col_res(c), expect_res(vin[c]));
    end
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", int'(done), 0);
    bad_hold = 0;
    repeat (20) begin
      @(negedge clk);
      if (ramp_code != MAXV || done || col_res(1) != expect_res(vin[1]))
        bad_hold++;
    end
    chk(bad_hold == 0, "R1", "held start gives no new conversion", bad_hold, 0);
  endtask

  initial begin
    for (int c = 0; c < NCOL; c++) vin[c] = 5000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ramp_code == 0, "R9", "reset ramp", int'(ramp_code), 0);
    chk(done == 1'b0, "R9", "reset done", int'(done), 0);
    for (int c = 0; c < NCOL; c += 7)
      chk(col_res(c) == 0, "R9", "reset result", col_res(c), 0);

    // R4: small consecutive inputs
    for (int c = 0; c < NCOL; c++) vin[c] = c;
    run_conv("R4", 0);

    // R3: captures just across multiples of 128
    for (int c = 0; c < NCOL; c++) vin[c] = c * 128 + 127;
    run_conv("R3", 0);

    // R6: near and beyond full scale plus a spread
    for (int c = 0; c < NCOL; c++)
      vin[c] = (c < 5) ? 4097 - c : (c * 977 + 13) % 4095;
    run_conv("R6", 0);

    // R5: comparators chatter after firing
    glitch = 1'b1;
    for (int c = 0; c < NCOL; c++) vin[c] = c * 100 + 2;
    run_conv("R5", 0);
    glitch = 1'b0;

    // R8: restart in mid conversion
    for (int c = 0; c < NCOL; c++) vin[c] = c * 10 + 5;
    run_conv("R8", 300);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule